// File: doc/BRIEF.md
# Ring Buffer Packet Readout DMA

This engine lifts one received packet out of a circular receive area that lives in paged memory and streams it, byte by byte, to the host side. A single command pulse starts it. The engine takes its first read address from the current boundary page. It learns the packet length from the packet's own four-byte header in memory, and it follows the ring across its upper limit back to the lower limit. When the last byte has gone out, it publishes a new boundary page so that the freed pages can take new packets.

Memory is addressed as a page number followed by an 8-bit offset, so each page holds 256 bytes. The memory read port has one cycle of latency. The engine keeps a single read outstanding, which gives one byte every two cycles. The header itself is streamed to the host and counts towards the packet length.

Top module: `ring_pkt_dma`

## Requirements
- R1: When `sendCmd` is high at a clock edge while the engine is idle and `cntHiPreload` equals 0x0F, the engine starts. In the next cycle it drives `memRd` high with `memAddr` = {`bndryIn`, 0x00}.
- R2: When `sendCmd` is high at a clock edge while the engine is idle and `cntHiPreload` is not 0x0F, `illegalStart` is high for exactly the next cycle. No read is issued and `busy` stays low.
- R3: The first four bytes of a packet form its header. Byte 0 is status, byte 1 is the next-page pointer, byte 2 is the length low byte and byte 3 is the length high byte. The header bytes are streamed out and are included in the 16-bit length.
- R4: Read data must arrive on `memData` one cycle after `memRd`. Byte k of a packet (k counted from 0) is presented on `outData` with `outValid` high exactly 2k+2 cycles after the start edge. `memRd` is never high in two adjacent cycles.
- R5: After each byte is read, the offset advances by one. When the offset passes 0xFF, it returns to 0x00 and the page advances by one.
- R6: When the page would advance to `pageStop`, it becomes `pageStart` instead.
- R7: A packet ends after as many bytes as its length field gives. A length below 4 is treated as 4, so the header is always sent whole.
- R8: `done` is high for one cycle, in the same cycle as the last byte's `outValid`. `busy` is low in that cycle.
- R9: `bndryOut` takes the packet's next-page pointer in the cycle `done` is high, and it holds its value at every other time. Its reset value is 0.
- R10: `sendCmd` pulses while the engine is busy have no effect on the reads or on the stream.
- R11: A new command is accepted in the cycle `done` is high or at any later point, so the next packet in the ring can be read at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sendCmd | input | 1 | Start pulse for one packet readout |
| cntHiPreload | input | 8 | Preloaded upper count byte; must be 0x0F to arm the engine |
| pageStart | input | PAGE_W | First page of the ring |
| pageStop | input | PAGE_W | Page just past the end of the ring |
| bndryIn | input | PAGE_W | Page where the next packet begins |
| memRd | output | 1 | Memory read strobe |
| memAddr | output | PAGE_W+8 | Memory read address, {page, offset} |
| memData | input | 8 | Read data, valid one cycle after `memRd` |
| outData | output | 8 | Streamed packet byte |
| outValid | output | 1 | `outData` holds a valid byte |
| busy | output | 1 | A packet readout is in progress |
| done | output | 1 | One-cycle completion pulse |
| illegalStart | output | 1 | One-cycle pulse for an unarmed command |
| bndryOut | output | PAGE_W | Updated boundary page |

## Verification
Every result has a fixed cycle after the start edge. The read of byte k is due 2k cycles after that edge and the byte appears 2k+2 cycles after it. `done` and the new boundary page come out together with the last byte, and `illegalStart` follows its command by one cycle. The bench counts clock edges from each command and checks `memRd`, `memAddr`, `outValid`, `outData`, `busy`, `done` and `bndryOut` against those counts. It samples in the middle of every cycle of the packet and in one quiet cycle after it, so a result that comes early or late fails just as a wrong value does.

// File: rtl/ringdma_pkg.sv
package ringdma_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ARM_KEY = 8'h0F;
  localparam int unsigned HDR_LEN = 4;

  typedef struct packed {
    logic start;     // load address from boundary page
    logic capture;   // take memData, step address
    logic grabNext;  // header byte 1
    logic grabLo;    // header byte 2
    logic loadCnt;   // header byte 3
    logic bodyByte;  // payload byte, count down
    logic finish;    // last byte of packet
  } dmaCtl_t;
endpackage

// File: rtl/ring_pkt_dma_datapath.sv
module ring_pkt_dma_datapath
  import ringdma_pkg::*;
#(
  parameter int unsigned PAGE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dmaCtl_t                  ctl,
  input  logic [PAGE_W-1:0]        pageStart,
  input  logic [PAGE_W-1:0]        pageStop,
  input  logic [PAGE_W-1:0]        bndryIn,
  input  logic [BYTE_W-1:0]        memData,
  output logic [PAGE_W+BYTE_W-1:0] memAddr,
  output logic [BYTE_W-1:0]        outData,
  output logic [PAGE_W-1:0]        bndryOut,
  output logic                     hdrShort,
  output logic                     cntIsOne
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic [PAGE_W-1:0] rdPage, nextPg, pageInc;
  logic [BYTE_W-1:0] rdOff, cntLo;
  logic [CNT_W-1:0]  remCnt, total;

  assign pageInc  = rdPage + PAGE_W'(1);
  assign total    = {memData, cntLo};
  assign hdrShort = total <= CNT_W'(HDR_LEN);
  assign cntIsOne = remCnt == CNT_W'(1);
  assign memAddr  = {rdPage, rdOff};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPage   <= '0;
      rdOff    <= '0;
      nextPg   <= '0;
      cntLo    <= '0;
      remCnt   <= '0;
      outData  <= '0;
      bndryOut <= '0;
    end else begin
      if (ctl.start) begin
        rdPage <= bndryIn;
        rdOff  <= '0;
      end
      if (ctl.capture) begin
        outData <= memData;
        rdOff   <= rdOff + BYTE_W'(1);
        if (rdOff == {BYTE_W{1'b1}})
          rdPage <= (pageInc == pageStop) ? pageStart : pageInc;
      end
      if (ctl.grabNext) nextPg <= PAGE_W'(memData);
      if (ctl.grabLo)   cntLo  <= memData;
      if (ctl.loadCnt)  remCnt <= hdrShort ? '0 : total - CNT_W'(HDR_LEN);
      if (ctl.bodyByte) remCnt <= remCnt - CNT_W'(1);
      if (ctl.finish)   bndryOut <= nextPg;
    end
  end
endmodule

// File: rtl/ring_pkt_dma_ctrl.sv
module ring_pkt_dma_ctrl
  import ringdma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sendCmd,
  input  logic [BYTE_W-1:0] cntHiPreload,
  input  logic              hdrShort,
  input  logic              cntIsOne,
  output dmaCtl_t           ctl,
  output logic              memRd,
  output logic              busy,
  output logic              outValid,
  output logic              done,
  output logic              illegalStart
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_TAKE} state_t;

  state_t    state, stateNxt;
  logic [1:0] hdrIdx;
  logic       inBody;
  logic       cmdSeen;

  assign cmdSeen = (state == S_IDLE) && sendCmd;
  assign memRd   = state == S_READ;
  assign busy    = state != S_IDLE;

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    unique case (state)
      S_IDLE: if (cmdSeen && cntHiPreload == ARM_KEY) begin
        ctl.start = 1'b1;
        stateNxt  = S_READ;
      end
      S_READ: stateNxt = S_TAKE;
      S_TAKE: begin
        ctl.capture = 1'b1;
        if (inBody) begin
          ctl.bodyByte = 1'b1;
          ctl.finish   = cntIsOne;
        end else begin
          ctl.grabNext = hdrIdx == 2'd1;
          ctl.grabLo   = hdrIdx == 2'd2;
          ctl.loadCnt  = hdrIdx == 2'd3;
          ctl.finish   = (hdrIdx == 2'd3) && hdrShort;
        end
        stateNxt = ctl.finish ? S_IDLE : S_READ;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= S_IDLE;
      hdrIdx       <= '0;
      inBody       <= 1'b0;
      outValid     <= 1'b0;
      done         <= 1'b0;
      illegalStart <= 1'b0;
    end else begin
      state        <= stateNxt;
      outValid     <= ctl.capture;
      done         <= ctl.finish;
      illegalStart <= cmdSeen && (cntHiPreload != ARM_KEY);
      if (ctl.start) begin
        hdrIdx <= '0;
        inBody <= 1'b0;
      end else if (ctl.capture && !inBody) begin
        hdrIdx <= hdrIdx + 2'd1;
        if (ctl.loadCnt && !hdrShort) inBody <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ring_pkt_dma.sv
module ring_pkt_dma
  import ringdma_pkg::*;
#(
  parameter int unsigned PAGE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sendCmd,
  input  logic [7:0]               cntHiPreload,
  input  logic [PAGE_W-1:0]        pageStart,
  input  logic [PAGE_W-1:0]        pageStop,
  input  logic [PAGE_W-1:0]        bndryIn,
  output logic                     memRd,
  output logic [PAGE_W+7:0]        memAddr,
  input  logic [7:0]               memData,
  output logic [7:0]               outData,
  output logic                     outValid,
  output logic                     busy,
  output logic                     done,
  output logic                     illegalStart,
  output logic [PAGE_W-1:0]        bndryOut
);
  dmaCtl_t ctl;
  logic    hdrShort, cntIsOne;

  ring_pkt_dma_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .sendCmd(sendCmd), .cntHiPreload(cntHiPreload),
    .hdrShort(hdrShort), .cntIsOne(cntIsOne), .ctl(ctl), .memRd(memRd),
    .busy(busy), .outValid(outValid), .done(done), .illegalStart(illegalStart)
  );

  ring_pkt_dma_datapath #(.PAGE_W(PAGE_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pageStart(pageStart),
    .pageStop(pageStop), .bndryIn(bndryIn), .memData(memData),
    .memAddr(memAddr), .outData(outData), .bndryOut(bndryOut),
    .hdrShort(hdrShort), .cntIsOne(cntIsOne)
  );
endmodule

// File: rtl/ring_pkt_dma_chk.sv
module ring_pkt_dma_chk #(
  parameter int unsigned PAGE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sendCmd,
  input logic [7:0]        cntHiPreload,
  input logic [PAGE_W-1:0] bndryIn,
  input logic              memRd,
  input logic [PAGE_W+7:0] memAddr,
  input logic              outValid,
  input logic              busy,
  input logic              done,
  input logic              illegalStart,
  input logic [PAGE_W-1:0] bndryOut
);
  p_start_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sendCmd && !busy && cntHiPreload == 8'h0F) |=>
      (memRd && memAddr == {$past(bndryIn), 8'h00}));

  p_illegal_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    illegalStart |-> (!memRd && !busy));

  p_illegal_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    illegalStart |=> !illegalStart || $past(sendCmd));

  p_one_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> !memRd);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_with_byte_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (outValid && !busy));

  p_bndry_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(bndryOut));
endmodule

bind ring_pkt_dma ring_pkt_dma_chk #(.PAGE_W(PAGE_W)) i_chk (
  .clk(clk), .rstN(rstN), .sendCmd(sendCmd), .cntHiPreload(cntHiPreload),
  .bndryIn(bndryIn), .memRd(memRd), .memAddr(memAddr), .outValid(outValid),
  .busy(busy), .done(done), .illegalStart(illegalStart), .bndryOut(bndryOut)
);

// File: tb/test_ring_pkt_dma.sv
module test_ring_pkt_dma;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sendCmd = 1'b0;
  logic [7:0]    cntHiPreload = 8'h0F;
  logic [PW-1:0] pageStart = 8'h40;
  logic [PW-1:0] pageStop = 8'h60;
  logic [PW-1:0] bndryIn = '0;
  logic          memRd;
  logic [PW+7:0] memAddr;
  logic [7:0]    memData = '0;
  logic [7:0]    outData;
  logic          outValid, busy, done, illegalStart;
  logic [PW-1:0] bndryOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_pkt_dma #(.PAGE_W(PW)) i_ring_pkt_dma (
    .clk(clk), .rstN(rstN), .sendCmd(sendCmd), .cntHiPreload(cntHiPreload),
    .pageStart(pageStart), .pageStop(pageStop), .bndryIn(bndryIn),
    .memRd(memRd), .memAddr(memAddr), .memData(memData), .outData(outData),
    .outValid(outValid), .busy(busy), .done(done), .illegalStart(illegalStart),
    .bndryOut(bndryOut)
  );

  always @(posedge clk)
    if (memRd) memData <= mem.exists(int'(memAddr)) ? mem[int'(memAddr)] : 8'h00;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int stepAddr(input int a);
    int pg = a >> 8;
    int off = a & 8'hFF;
    if (off == 255) begin
      pg = pg + 1;
      if (pg == int'(pageStop)) pg = int'(pageStart);
      return pg << 8;
    end
    return a + 1;
  endfunction

  // Lays a packet into memory, runs it, checks every cycle (R1,R3-R10).
  task automatic runPkt(input int bp, input int len, input int nxt,
                        input int seed, input bit poke);
    int n = (len < 4) ? 4 : len;
    int addrQ[$];
    int dataQ[$];
    int a = bp << 8;
    int oldBnd = int'(bndryOut);
    for (int i = 0; i < n; i++) begin
      int b;
      case (i)
        0: b = 8'h01;
        1: b = nxt;
        2: b = len & 8'hFF;
        3: b = (len >> 8) & 8'hFF;
        default: b = (seed + i * 7) & 8'hFF;
      endcase
      mem[a] = b[7:0];
      addrQ.push_back(a);
      dataQ.push_back(b);
      a = stepAddr(a);
    end
    cntHiPreload = 8'h0F;
    bndryIn = bp[PW-1:0];
    sendCmd = 1'b1;
    for (int j = 0; j <= 2 * n + 1; j++) begin
      @(negedge clk);
      if (j == 0) sendCmd = 1'b0;
      if (poke && j == 3) begin
        sendCmd = 1'b1;
        bndryIn = bndryIn + 8'h05;
      end
      if (poke && j == 4) sendCmd = 1'b0;
      begin
        bit expRd = (j % 2 == 0) && (j <= 2 * n - 2);
        bit expOv = (j % 2 == 0) && (j >= 2) && (j <= 2 * n);
        chk(memRd == expRd, "R4", "memRd", memRd, expRd);
        if (expRd && memRd)
          chk(int'(memAddr) == addrQ[j/2], (j == 0) ? "R1" : "R5/R6",
              "memAddr", memAddr, addrQ[j/2]);
        chk(outValid == expOv, "R4/R7", "outValid", outValid, expOv);
        if (expOv && outValid)
          chk(int'(outData) == dataQ[j/2-1], "R3", "outData", outData, dataQ[j/2-1]);
        chk(done == (j == 2 * n), "R8", "done", done, j == 2 * n);
        chk(busy == (j < 2 * n), "R8", "busy", busy, j < 2 * n);
        chk(int'(bndryOut) == ((j >= 2 * n) ? nxt : oldBnd), "R9", "bndryOut",
            bndryOut, (j >= 2 * n) ? nxt : oldBnd);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !memRd && !outValid && !done && !illegalStart, "R9", "reset idle",
        {busy, memRd, outValid, done, illegalStart}, 0);
    chk(bndryOut == '0, "R9", "reset bndryOut", bndryOut, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: unarmed command
    cntHiPreload = 8'h00;
    bndryIn = 8'h46;
    sendCmd = 1'b1;
    @(negedge clk);
    sendCmd = 1'b0;
    chk(illegalStart == 1'b1, "R2", "illegalStart", illegalStart, 1);
    chk(!memRd && !busy, "R2", "no read", {memRd, busy}, 0);
    @(negedge clk);
    chk(illegalStart == 1'b0, "R2", "illegalStart pulse", illegalStart, 0);
    chk(!memRd && !busy, "R2", "still idle", {memRd, busy}, 0);

    runPkt(8'h46, 10, 8'h47, 8'h10, 1'b1);   // R10: poke while busy
    runPkt(8'h5F, 300, 8'h41, 8'h33, 1'b0);  // R6: wraps stop -> start
    runPkt(int'(bndryOut), 260, 8'h44, 8'h55, 1'b0); // R11, R5 page step
    runPkt(8'h48, 2, 8'h49, 8'h00, 1'b0);    // R7: short length
    runPkt(8'h49, 4, 8'h4A, 8'h00, 1'b0);    // R7: header only

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule